// File: doc/BRIEF.md
# Bit-test execution unit

This unit carries out the bit-test operation of a CPU whose accumulator can be switched between 8 and 16 bits. The decoder hands it the opcode byte, the accumulator, the fetched memory operand, the width setting, the low byte of the direct-page base register, and the base address and index used for indexed addressing. The unit ANDs the accumulator with the operand without keeping the result. It produces the new zero, negative and overflow flag values, each with its own write strobe. It also reports the instruction length in bytes and the total number of cycles the instruction takes.

Five opcodes are accepted. The immediate form only updates the zero flag. The memory forms also copy the top two operand bits into the negative and overflow flags. The cycle total starts from a base count for each mode. One extra cycle is added for a wide accumulator, one for a misaligned direct page in the direct-page modes, and one for a page crossing in the absolute indexed mode. Any other opcode is flagged as invalid and changes nothing. All results are registered one clock after the input strobe. No other status flag is driven by this unit.

Top module: `bittest_unit`

## Requirements
- R1: For every accepted opcode, z_we is 1 and z_flag is 1 exactly when (acc AND operand) is zero over the active width (16 bits when acc_wide=1, the low 8 bits when acc_wide=0).
- R2: For the memory modes (0x2C, 0x24, 0x3C, 0x34), n_we and v_we are 1. n_flag is operand bit 15 and v_flag is operand bit 14 when acc_wide=1. They are bits 7 and 6 when acc_wide=0.
- R3: For the immediate opcode 0x89, n_we and v_we are 0 and n_flag/v_flag read 0.
- R4: Opcodes are decoded as 0x89 immediate, 0x2C absolute, 0x24 direct page, 0x3C absolute indexed and 0x34 direct-page indexed. Each of these gives invalid=0.
- R5: length is 3 for absolute and absolute indexed, and 2 for direct page and direct-page indexed. For immediate it is 2 when acc_wide=0 and 3 when acc_wide=1.
- R6: The base cycle count is 2 for immediate, 4 for absolute, 3 for direct page, 4 for absolute indexed and 4 for direct-page indexed.
- R7: acc_wide=1 adds one cycle in every mode.
- R8: In the two direct-page modes only, a nonzero dp_low adds one cycle. In the other modes dp_low has no effect.
- R9: In absolute indexed mode only, one cycle is added when ea_base+ea_index has a different upper byte (bits 15:8) than ea_base. Absolute mode ignores the index.
- R10: Any other opcode gives invalid=1, all write enables 0, length 0 and cycles 0.
- R11: Results appear on the clock edge after in_valid is sampled high. out_valid is high for exactly that one cycle. With in_valid low, out_valid stays 0. After reset, out_valid is 0.
- R12: With acc_wide=0, bits 15:8 of acc and operand affect no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 8 | Opcode byte |
| acc | input | 16 | Accumulator value |
| operand | input | 16 | Memory or immediate operand |
| acc_wide | input | 1 | 1 = 16-bit accumulator, 0 = 8-bit |
| dp_low | input | 8 | Low byte of the direct-page base register |
| ea_base | input | 16 | Base address before indexing |
| ea_index | input | 16 | Index value |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| invalid | output | 1 | Opcode not recognised |
| n_flag | output | 1 | New negative flag value |
| v_flag | output | 1 | New overflow flag value |
| z_flag | output | 1 | New zero flag value |
| n_we | output | 1 | Write enable for negative flag |
| v_we | output | 1 | Write enable for overflow flag |
| z_we | output | 1 | Write enable for zero flag |
| length | output | 2 | Instruction length in bytes |
| cycles | output | 3 | Total cycle count |

## Verification
The width penalty can land on the same instruction as either address penalty. A wide direct-page indexed operation with a misaligned direct page must report 4+1+1 = 6 cycles. A wide absolute indexed operation that crosses a page must also report 6. The bench drives both combinations and also each penalty alone, and compares the result against a model built from the rules above. The bench also pairs each addressing penalty with the mode that must ignore it: a nonzero dp_low in absolute mode and a crossing index in absolute mode. This shows that each penalty is gated by the mode and does not leak into other modes.

// File: rtl/bittest_pkg.sv
package bittest_pkg;
  localparam int LEN_W = 2;
  localparam int CYC_W = 3;

  localparam logic [7:0] OPC_IMM  = 8'h89;
  localparam logic [7:0] OPC_ABS  = 8'h2C;
  localparam logic [7:0] OPC_DP   = 8'h24;
  localparam logic [7:0] OPC_ABSX = 8'h3C;
  localparam logic [7:0] OPC_DPX  = 8'h34;

  typedef enum logic [2:0] {
    MODE_IMM, MODE_ABS, MODE_DP, MODE_ABSX, MODE_DPX, MODE_NONE
  } amode_t;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic n_we;
    logic v_we;
    logic z_we;
  } flag_upd_t;
endpackage

// File: rtl/bittest_decode.sv
module bittest_decode
  import bittest_pkg::*;
(
  input  logic [7:0] opcode,
  output amode_t     mode,
  output logic       known
);
  always_comb begin
    case (opcode)
      OPC_IMM:  mode = MODE_IMM;
      OPC_ABS:  mode = MODE_ABS;
      OPC_DP:   mode = MODE_DP;
      OPC_ABSX: mode = MODE_ABSX;
      OPC_DPX:  mode = MODE_DPX;
      default:  mode = MODE_NONE;
    endcase
    known = (mode != MODE_NONE);
  end
endmodule

// File: rtl/bittest_flags.sv
module bittest_flags
  import bittest_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  input  logic              wide,
  input  amode_t            mode,
  output flag_upd_t         upd
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] conj;
  logic              top_bit;
  logic              next_bit;

  always_comb begin
    width_mask = wide ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    conj       = acc & operand & width_mask;
    top_bit    = wide ? operand[DATA_W-1] : operand[HALF_W-1];
    next_bit   = wide ? operand[DATA_W-2] : operand[HALF_W-2];

    upd = '0;
    case (mode)
      MODE_IMM: begin
        upd.z_we = 1'b1;
        upd.z    = (conj == '0);
      end
      MODE_ABS, MODE_DP, MODE_ABSX, MODE_DPX: begin
        upd.z_we = 1'b1;
        upd.z    = (conj == '0);
        upd.n_we = 1'b1;
        upd.n    = top_bit;
        upd.v_we = 1'b1;
        upd.v    = next_bit;
      end
      default: upd = '0;
    endcase
  end
endmodule

// File: rtl/bittest_timing.sv
module bittest_timing
  import bittest_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input  amode_t             mode,
  input  logic               wide,
  input  logic [PAGE_W-1:0]  dp_low,
  input  logic [ADDR_W-1:0]  ea_base,
  input  logic [ADDR_W-1:0]  ea_index,
  output logic [LEN_W-1:0]   length,
  output logic [CYC_W-1:0]   cycles
);
  logic [ADDR_W-1:0] ea_sum;
  logic              page_cross;
  logic              dp_misaligned;
  logic [CYC_W-1:0]  base_cyc;
  logic [CYC_W-1:0]  pen_wide;
  logic [CYC_W-1:0]  pen_dp;
  logic [CYC_W-1:0]  pen_page;

  always_comb begin
    ea_sum        = ea_base + ea_index;
    page_cross    = (ea_sum[ADDR_W-1:PAGE_W] != ea_base[ADDR_W-1:PAGE_W]);
    dp_misaligned = (dp_low != '0);

    base_cyc = '0;
    length   = '0;
    pen_dp   = '0;
    pen_page = '0;
    case (mode)
      MODE_IMM: begin
        base_cyc = CYC_W'(2);
        length   = wide ? LEN_W'(3) : LEN_W'(2);
      end
      MODE_ABS: begin
        base_cyc = CYC_W'(4);
        length   = LEN_W'(3);
      end
      MODE_DP: begin
        base_cyc = CYC_W'(3);
        length   = LEN_W'(2);
        pen_dp   = CYC_W'(dp_misaligned);
      end
      MODE_ABSX: begin
        base_cyc = CYC_W'(4);
        length   = LEN_W'(3);
        pen_page = CYC_W'(page_cross);
      end
      MODE_DPX: begin
        base_cyc = CYC_W'(4);
        length   = LEN_W'(2);
        pen_dp   = CYC_W'(dp_misaligned);
      end
      default: begin
        base_cyc = '0;
        length   = '0;
      end
    endcase
    pen_wide = (mode != MODE_NONE) ? CYC_W'(wide) : '0;
    cycles   = base_cyc + pen_wide + pen_dp + pen_page;
  end
endmodule

// File: rtl/bittest_unit.sv
module bittest_unit
  import bittest_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] operand,
  input  logic              acc_wide,
  input  logic [PAGE_W-1:0] dp_low,
  input  logic [ADDR_W-1:0] ea_base,
  input  logic [ADDR_W-1:0] ea_index,
  output logic              out_valid,
  output logic              invalid,
  output logic              n_flag,
  output logic              v_flag,
  output logic              z_flag,
  output logic              n_we,
  output logic              v_we,
  output logic              z_we,
  output logic [LEN_W-1:0]  length,
  output logic [CYC_W-1:0]  cycles
);
  // reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_chain;
  logic                   rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain <= '0;
    else        rst_chain <= {rst_chain[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s = rst_chain[SYNC_STAGES-1];

  amode_t            mode;
  logic              known;
  flag_upd_t         upd;
  logic [LEN_W-1:0]  len_c;
  logic [CYC_W-1:0]  cyc_c;

  bittest_decode u_decode (
    .opcode (opcode),
    .mode   (mode),
    .known  (known)
  );

  bittest_flags #(.DATA_W(DATA_W)) u_flags (
    .acc     (acc),
    .operand (operand),
    .wide    (acc_wide),
    .mode    (mode),
    .upd     (upd)
  );

  bittest_timing #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_timing (
    .mode     (mode),
    .wide     (acc_wide),
    .dp_low   (dp_low),
    .ea_base  (ea_base),
    .ea_index (ea_index),
    .length   (len_c),
    .cycles   (cyc_c)
  );

  // next-state
  flag_upd_t        upd_q, upd_d;
  logic             inv_q, inv_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             vld_q, vld_d;
  logic             cap_en;

  always_comb begin
    cap_en = in_valid;
    vld_d  = in_valid;
    upd_d  = upd_q;
    inv_d  = inv_q;
    len_d  = len_q;
    cyc_d  = cyc_q;
    if (cap_en) begin
      upd_d = upd;
      inv_d = !known;
      len_d = len_c;
      cyc_d = cyc_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      vld_q <= 1'b0;
      upd_q <= '0;
      inv_q <= 1'b0;
      len_q <= '0;
      cyc_q <= '0;
    end else begin
      vld_q <= vld_d;
      upd_q <= upd_d;
      inv_q <= inv_d;
      len_q <= len_d;
      cyc_q <= cyc_d;
    end
  end

  assign out_valid = vld_q;
  assign invalid   = inv_q;
  assign n_flag    = upd_q.n;
  assign v_flag    = upd_q.v;
  assign z_flag    = upd_q.z;
  assign n_we      = upd_q.n_we;
  assign v_we      = upd_q.v_we;
  assign z_we      = upd_q.z_we;
  assign length    = len_q;
  assign cycles    = cyc_q;

  // R11: result strobe follows the input strobe by one clock
  p_strobe_follow_r11: assert property (@(posedge clk) disable iff (!rst_s)
    in_valid |=> out_valid);
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_s)
    !in_valid |=> !out_valid);
  // R10: an unknown opcode leaves everything quiet
  p_invalid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && invalid) |-> (!n_we && !v_we && !z_we && length == '0 && cycles == '0));
  // R1: every accepted opcode writes Z
  p_zero_written_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !invalid) |-> z_we);
  // R2 / R3: N and V are written together or not at all
  p_nv_paired_r2: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> (n_we == v_we));
  // R6 / R7: cycle totals stay between two and six
  p_cycle_range_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !invalid) |-> (cycles >= CYC_W'(2) && cycles <= CYC_W'(6)));
  // R5: accepted opcodes are two or three bytes long
  p_length_range_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !invalid) |-> (length == LEN_W'(2) || length == LEN_W'(3)));
endmodule

// File: tb/bittest_unit_bench.sv
module bittest_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  opcode;
  logic [15:0] acc;
  logic [15:0] operand;
  logic        acc_wide;
  logic [7:0]  dp_low;
  logic [15:0] ea_base;
  logic [15:0] ea_index;
  logic        out_valid, invalid, n_flag, v_flag, z_flag, n_we, v_we, z_we;
  logic [1:0]  length;
  logic [2:0]  cycles;

  int checks = 0;
  int errors = 0;

  bittest_unit u_bittest_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .acc(acc), .operand(operand), .acc_wide(acc_wide), .dp_low(dp_low),
    .ea_base(ea_base), .ea_index(ea_index), .out_valid(out_valid),
    .invalid(invalid), .n_flag(n_flag), .v_flag(v_flag), .z_flag(z_flag),
    .n_we(n_we), .v_we(v_we), .z_we(z_we), .length(length), .cycles(cycles)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // one operation: drive, wait one edge, compare with model
  task automatic run_op(input string tag, input logic [7:0] opc, input logic [15:0] a,
                        input logic [15:0] m, input logic w, input logic [7:0] dpl,
                        input logic [15:0] base, input logic [15:0] idx);
    bit known, imm, absm, absx, dpm;
    int e_len, e_cyc;
    logic [15:0] mask, sum;
    bit e_z, e_n, e_v;
    @(negedge clk);
    in_valid = 1'b1; opcode = opc; acc = a; operand = m; acc_wide = w;
    dp_low = dpl; ea_base = base; ea_index = idx;
    imm   = (opc == 8'h89);
    absm  = (opc == 8'h2C);
    absx  = (opc == 8'h3C);
    dpm   = (opc == 8'h24) || (opc == 8'h34);
    known = imm || absm || absx || dpm;
    mask  = w ? 16'hFFFF : 16'h00FF;
    e_z   = ((a & m & mask) == 16'h0);
    e_n   = w ? m[15] : m[7];
    e_v   = w ? m[14] : m[6];
    sum   = base + idx;
    e_len = 0; e_cyc = 0;
    if (imm)       begin e_len = w ? 3 : 2; e_cyc = 2; end
    if (absm)      begin e_len = 3; e_cyc = 4; end
    if (absx)      begin e_len = 3; e_cyc = 4 + ((sum[15:8] != base[15:8]) ? 1 : 0); end
    if (opc == 8'h24) begin e_len = 2; e_cyc = 3; end
    if (opc == 8'h34) begin e_len = 2; e_cyc = 4; end
    if (dpm && dpl != 8'h0) e_cyc++;
    if (known && w) e_cyc++;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "out_valid", out_valid, 1);
    chk(tag, "invalid", invalid, known ? 0 : 1);
    chk(tag, "z_we", z_we, known ? 1 : 0);
    if (known) chk(tag, "z_flag", z_flag, e_z);
    chk(tag, "n_we", n_we, (known && !imm) ? 1 : 0);
    chk(tag, "v_we", v_we, (known && !imm) ? 1 : 0);
    if (known && !imm) begin
      chk(tag, "n_flag", n_flag, e_n);
      chk(tag, "v_flag", v_flag, e_v);
    end
    chk(tag, "length", length, e_len);
    chk(tag, "cycles", cycles, e_cyc);
  endtask

  task automatic t_reset();
    chk("R11", "reset out_valid", out_valid, 0);
    chk("R11", "reset z_we", z_we, 0);
    chk("R11", "reset cycles", cycles, 0);
  endtask

  task automatic t_immediate();
    run_op("R3", 8'h89, 16'h00F0, 16'h000F, 1'b0, 8'h0, 16'h0, 16'h0);   // Z=1
    run_op("R3", 8'h89, 16'h00F0, 16'h00C0, 1'b0, 8'h0, 16'h0, 16'h0);   // Z=0
    run_op("R5", 8'h89, 16'h8000, 16'hC000, 1'b1, 8'h0, 16'h0, 16'h0);   // wide, len 3
    chk("R3", "imm n_flag", n_flag, 0);
  endtask

  task automatic t_memory_flags();
    run_op("R2", 8'h2C, 16'h0001, 16'h00C1, 1'b0, 8'h0, 16'h1234, 16'h0);
    run_op("R2", 8'h2C, 16'h0000, 16'h4080, 1'b1, 8'h0, 16'h1234, 16'h0);
    run_op("R2", 8'h24, 16'hFFFF, 16'h0040, 1'b0, 8'h0, 16'h0, 16'h0);
    run_op("R1", 8'h24, 16'h0F00, 16'hF0FF, 1'b1, 8'h0, 16'h0, 16'h0);   // wide, Z=1
    run_op("R4", 8'h34, 16'h0003, 16'h0002, 1'b0, 8'h0, 16'h0, 16'h0);
    run_op("R4", 8'h3C, 16'h0003, 16'h0004, 1'b0, 8'h0, 16'h1000, 16'h0010);
  endtask

  task automatic t_masking();
    // high bytes would flip Z and N/V if not masked
    run_op("R12", 8'h2C, 16'hFF00, 16'hFF3F, 1'b0, 8'h0, 16'h0, 16'h0);
    chk("R12", "narrow z", z_flag, 1);
    chk("R12", "narrow n", n_flag, 0);
  endtask

  task automatic t_dp_penalty();
    run_op("R8", 8'h24, 16'h1, 16'h1, 1'b0, 8'h01, 16'h0, 16'h0);    // 4
    run_op("R8", 8'h34, 16'h1, 16'h1, 1'b0, 8'h80, 16'h0, 16'h0);    // 5
    run_op("R8", 8'h2C, 16'h1, 16'h1, 1'b0, 8'hFF, 16'h0, 16'h0);    // ignored: 4
    chk("R8", "abs ignores dp", cycles, 4);
    run_op("R8", 8'h89, 16'h1, 16'h1, 1'b0, 8'h55, 16'h0, 16'h0);    // ignored: 2
  endtask

  task automatic t_page_penalty();
    run_op("R9", 8'h3C, 16'h1, 16'h1, 1'b0, 8'h0, 16'h10F0, 16'h0010); // cross: 5
    chk("R9", "absx cross", cycles, 5);
    run_op("R9", 8'h3C, 16'h1, 16'h1, 1'b0, 8'h0, 16'h10F0, 16'h000F); // no cross: 4
    run_op("R9", 8'h2C, 16'h1, 16'h1, 1'b0, 8'h0, 16'h10F0, 16'h0010); // abs ignores: 4
    chk("R9", "abs ignores index", cycles, 4);
    run_op("R9", 8'h34, 16'h1, 16'h1, 1'b0, 8'h0, 16'h10F0, 16'h0010); // dpx ignores: 4
  endtask

  task automatic t_wide_penalty();
    run_op("R7", 8'h24, 16'h1, 16'h1, 1'b1, 8'h0, 16'h0, 16'h0);    // 4
    run_op("R6", 8'h2C, 16'h1, 16'h1, 1'b0, 8'h0, 16'h0, 16'h0);    // 4
  endtask

  task automatic t_combined();
    run_op("R7", 8'h34, 16'h1, 16'h1, 1'b1, 8'h02, 16'h0, 16'h0);   // 6
    chk("R8", "wide+dp", cycles, 6);
    run_op("R7", 8'h3C, 16'h1, 16'h1, 1'b1, 8'h0, 16'h00FF, 16'h0001); // 6
    chk("R9", "wide+cross", cycles, 6);
  endtask

  task automatic t_invalid();
    run_op("R10", 8'hEA, 16'hFFFF, 16'hFFFF, 1'b1, 8'h11, 16'h00FF, 16'h0001);
    run_op("R10", 8'h88, 16'h0, 16'h0, 1'b0, 8'h0, 16'h0, 16'h0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    chk("R11", "idle out_valid", out_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; opcode = 8'h0; acc = 16'h0; operand = 16'h0;
    acc_wide = 1'b0; dp_low = 8'h0; ea_base = 16'h0; ea_index = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_immediate();
    t_memory_flags();
    t_masking();
    t_dp_penalty();
    t_page_penalty();
    t_wide_penalty();
    t_combined();
    t_invalid();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule